// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It reads one or two descriptors from translation tables held in memory. When a walk starts, it picks one of two table base addresses by looking at the top `split_n` bits of the address. It then fetches a first-level descriptor, which can describe one of four things:

- a fault;
- a 1 MB section;
- a 16 MB supersection;
- a pointer to a second-level table.

Only the pointer case needs a second fetch. That fetch returns a descriptor that describes a fault, a 64 KB large page or a 4 KB small page.

A walk ends with a one-cycle `done` pulse. With it the block presents the physical address, the execute-never flag and a fault code, and holds them until the next walk ends. A TLB or table-walk sequencer that needs a translation uses this block. The block does not check access permissions or caching attributes, and it stores no translations.

The memory port works as follows. The block raises `mem_req` with a word-aligned `mem_addr`. It holds both steady until the cycle in which `mem_valid` is high, and it takes `mem_rdata` in that cycle. `mem_valid` may already be high in the first request cycle.

Top module: `ttw_walker`

## Requirements
- R1: A walk selects `base1` when any of the top `split_n` bits of the address is 1. Otherwise it selects `base0`; `split_n`=0 always selects `base0`. For `base0`, the first-level address is `base0` with bits [13-n:0] cleared, OR-ed with address bits [31-n:20] placed at bit 2. For `base1`, the first-level address is {base1[31:14], va[31:20], 2'b00}.
- R2: A first-level descriptor with type bits [1:0]=00 ends the walk after one fetch with fault code 1.
- R3: A first-level descriptor with type bits [1:0]=11 ends the walk after one fetch with fault code 2.
- R4: A first-level descriptor with type 10 and bit 18 = 0 is a section. The walk ends after one fetch with pa = {d[31:20], va[19:0]}, xn = d[4] and fault code 0.
- R5: A first-level descriptor with type 10 and bit 18 = 1 is a supersection. The walk ends after one fetch with pa = {d[31:24], va[23:0]}, xn = d[4] and fault code 0.
- R6: A first-level descriptor with type 01 starts a second fetch at {d[31:10], va[19:12], 2'b00}.
- R7: A second-level descriptor with type 00 ends the walk with fault code 3.
- R8: A second-level descriptor with type 01 is a large page: pa = {d[31:16], va[15:0]}, xn = d[15]. A descriptor copied into the 16 entries of an aligned group gives the same pa[31:16] for all 16 aliased addresses.
- R9: A second-level descriptor with type 10 or 11 is a small page: pa = {d[31:12], va[11:0]}, xn = d[0].
- R10: While `mem_req` is high and `mem_valid` is low, `mem_req` and `mem_addr` stay unchanged in the next cycle. `mem_addr` is always word-aligned.
- R11: `done` is high for exactly one cycle per walk. `pa`, `xn` and `fault` change only together with `done`. Any fault gives pa = 0 and xn = 0.
- R12: `start` is ignored while `busy` is high. The address, both bases and `split_n` are sampled only in the cycle the walk is accepted.
- R13: After reset the block is idle: `busy`, `mem_req` and `done` are 0, and `pa` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk when idle |
| start_va | input | 32 | Virtual address to translate |
| base0 | input | 32 | Table base used for low addresses |
| base1 | input | 32 | Table base used for high addresses |
| split_n | input | N_W | Number of top address bits that select the base |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | One-cycle walk completion pulse |
| pa | output | 32 | Physical address result |
| xn | output | 1 | Execute-never flag of the result |
| fault | output | 2 | 0 none, 1 first-level unmapped, 2 first-level reserved, 3 second-level unmapped |

## Verification
The assertions check on every cycle:
- the memory request stays steady until data returns;
- the alignment of descriptor addresses;
- the single-cycle `done` pulse and that the results hold between walks;
- the cleared result on a fault;
- that an idle start is accepted at once.

Only the bench scenarios can show that the table base is chosen correctly for each `split_n` and that the first- and second-level descriptor addresses are right. The same holds for the address that each of the seven descriptor kinds composes, and for aliased large-page lookups landing on the same page. The bench also changes every sampled input in the middle of a walk and pulses `start` while the block is busy, to show that a walk uses only what it sampled.

// File: rtl/ttw_pkg.sv
// Shared types for the translation table walker.
package ttw_pkg;

    // Fault codes reported with a finished walk.
    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_L1_UNMAPPED = 2'd1,
        FLT_L1_RESERVED = 2'd2,
        FLT_L2_UNMAPPED = 2'd3
    } fault_e;

    // Result of one decode step.
    typedef struct packed {
        logic [31:0] pa;
        logic        xn;
        fault_e      fault;
    } walk_res_t;

    // Walk sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2
    } state_e;

endpackage

// File: rtl/ttw_base_sel.sv
// Picks the table base from the top split_n address bits and forms the
// first-level descriptor address.
// Assumes split_n is at most 12.
module ttw_base_sel #(
    parameter int N_W = 3
) (
    input  logic [31:0]    va,
    input  logic [31:0]    base0,
    input  logic [31:0]    base1,
    input  logic [N_W-1:0] split_n,
    output logic [31:0]    l1_addr
);
    logic [31:0] top_mask;
    logic [31:0] low_mask;
    logic [11:0] idx;
    logic        use_hi;
    logic        unused_b1;

    assign unused_b1 = ^base1[13:0];

    // Find the table base and shrink the index for table 0.
    always_comb begin
        top_mask = ~(32'hFFFF_FFFF >> split_n);
        use_hi   = |(va & top_mask);
        low_mask = 32'h0000_3FFF >> split_n;
        idx      = va[31:20] & (12'hFFF >> split_n);
        if (use_hi) begin
            l1_addr = {base1[31:14], va[31:20], 2'b00};
        end else begin
            l1_addr = (base0 & ~low_mask) | {18'd0, idx, 2'b00};
        end
    end
endmodule

// File: rtl/ttw_l1_decode.sv
// Decodes a first-level descriptor into a final result (fault, section or
// supersection) or into the address of a second-level descriptor.
// Purely combinational.
module ttw_l1_decode
    import ttw_pkg::*;
(
    input  logic [31:0] desc,
    input  logic [31:0] va,
    output logic        is_ptr,
    output logic [31:0] l2_addr,
    output walk_res_t   res
);
    logic unused_bits;

    assign unused_bits = ^{desc[17:11], desc[3:2], va[31:24], va[11:0]};

    // Classify the descriptor by its type bits.
    always_comb begin
        is_ptr  = 1'b0;
        l2_addr = {desc[31:10], va[19:12], 2'b00};
        res     = '0;
        unique case (desc[1:0])
            2'b00: res.fault = FLT_L1_UNMAPPED;
            2'b01: is_ptr = 1'b1;
            2'b10: begin
                res.xn = desc[4];
                if (desc[18]) res.pa = {desc[31:24], va[23:0]};
                else          res.pa = {desc[31:20], va[19:0]};
            end
            default: res.fault = FLT_L1_RESERVED;
        endcase
    end
endmodule

// File: rtl/ttw_l2_decode.sv
// Decodes a second-level descriptor into a fault, a large page or a small page.
// Purely combinational.
module ttw_l2_decode
    import ttw_pkg::*;
(
    input  logic [31:0] desc,
    input  logic [31:0] va,
    output walk_res_t   res
);
    logic unused_bits;

    assign unused_bits = ^{desc[14:2], va[31:16]};

    // Build the page result from the descriptor type.
    always_comb begin
        res = '0;
        unique case (desc[1:0])
            2'b00: res.fault = FLT_L2_UNMAPPED;
            2'b01: begin
                res.pa = {desc[31:16], va[15:0]};
                res.xn = desc[15];
            end
            default: begin
                res.pa = {desc[31:12], va[11:0]};
                res.xn = desc[0];
            end
        endcase
    end
endmodule

// File: rtl/ttw_walker.sv
// Two-level translation table walker.
// It samples the request on start, fetches the first-level descriptor and,
// for a table pointer, the second-level descriptor. It then presents the
// result with a one-cycle done pulse.
// Assumes memory keeps mem_rdata valid in the cycle mem_valid is high.
module ttw_walker
    import ttw_pkg::*;
#(
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [31:0]    start_va,
    input  logic [31:0]    base0,
    input  logic [31:0]    base1,
    input  logic [N_W-1:0] split_n,
    output logic           busy,
    output logic           mem_req,
    output logic [31:0]    mem_addr,
    input  logic           mem_valid,
    input  logic [31:0]    mem_rdata,
    output logic           done,
    output logic [31:0]    pa,
    output logic           xn,
    output logic [1:0]     fault
);
    state_e      state;
    logic [31:0] va_q;
    logic [31:0] l1_addr_q;
    logic [31:0] l2_addr_q;
    walk_res_t   res_q;
    logic [31:0] sel_addr;
    logic        l1_is_ptr;
    logic [31:0] l1_next;
    walk_res_t   l1_res;
    walk_res_t   l2_res;

    ttw_base_sel #(.N_W(N_W)) i_base_sel (
        .va(start_va), .base0(base0), .base1(base1),
        .split_n(split_n), .l1_addr(sel_addr)
    );

    ttw_l1_decode i_l1_decode (
        .desc(mem_rdata), .va(va_q), .is_ptr(l1_is_ptr),
        .l2_addr(l1_next), .res(l1_res)
    );

    ttw_l2_decode i_l2_decode (
        .desc(mem_rdata), .va(va_q), .res(l2_res)
    );

    assign busy     = (state != ST_IDLE);
    assign mem_req  = busy;
    assign mem_addr = (state == ST_L2) ? l2_addr_q : l1_addr_q;
    assign pa       = res_q.pa;
    assign xn       = res_q.xn;
    assign fault    = res_q.fault;

    // Sequence the walk and capture the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            va_q      <= '0;
            l1_addr_q <= '0;
            l2_addr_q <= '0;
            res_q     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    va_q      <= start_va;
                    l1_addr_q <= sel_addr;
                    state     <= ST_L1;
                end
                ST_L1: if (mem_valid) begin
                    if (l1_is_ptr) begin
                        l2_addr_q <= l1_next;
                        state     <= ST_L2;
                    end else begin
                        res_q <= l1_res;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_L2: if (mem_valid) begin
                    res_q <= l2_res;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ttw_walker_chk.sv
// Protocol and result checker for ttw_walker, attached with bind.
module ttw_walker_chk #(
    parameter int N_W = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [31:0]    start_va,
    input logic [31:0]    base0,
    input logic [31:0]    base1,
    input logic [N_W-1:0] split_n,
    input logic           busy,
    input logic           mem_req,
    input logic [31:0]    mem_addr,
    input logic           mem_valid,
    input logic [31:0]    mem_rdata,
    input logic           done,
    input logic [31:0]    pa,
    input logic           xn,
    input logic [1:0]     fault
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

    p_addr_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_fault_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault != 2'd0 |-> pa == 32'd0 && !xn);

    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(pa) && $stable(xn) && $stable(fault) || done);

    p_start_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy && mem_req);
endmodule

bind ttw_walker ttw_walker_chk #(.N_W(N_W)) i_chk (.*);

// File: tb/test_ttw_walker.sv
`timescale 1ns/1ps
module test_ttw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_va = '0;
    logic [31:0] base0 = '0;
    logic [31:0] base1 = '0;
    logic [2:0]  split_n = '0;
    logic        busy, mem_req, done, xn;
    logic [31:0] mem_addr, pa;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ttw_walker #(.N_W(3)) i_ttw_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .start_va(start_va),
        .base0(base0), .base1(base1), .split_n(split_n), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .pa(pa), .xn(xn), .fault(fault)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        start = 1'b0;
    endtask

    // Expected first-level address, built bit by bit from the requirement.
    function automatic logic [31:0] exp_l1(input logic [31:0] va, input logic [31:0] b0,
                                           input logic [31:0] b1, input int n);
        logic hi = 1'b0;
        logic [31:0] a;
        for (int i = 0; i < n; i++) if (va[31-i]) hi = 1'b1;
        if (hi) return {b1[31:14], va[31:20], 2'b00};
        a = b0;
        for (int i = 0; i < 14 - n; i++) a[i] = 1'b0;
        for (int i = 20; i < 32 - n; i++) a[i-18] = va[i];
        return a;
    endfunction

    // Expected walk outcome.
    task automatic exp_walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2,
                            output bit two, output logic [31:0] a2, output logic [31:0] epa,
                            output logic exn, output logic [1:0] eflt);
        two = 0; a2 = '0; epa = '0; exn = 0; eflt = 2'd0;
        case (d1[1:0])
            2'b00: eflt = 2'd1;
            2'b11: eflt = 2'd2;
            2'b10: begin
                exn = d1[4];
                epa = d1[18] ? {d1[31:24], va[23:0]} : {d1[31:20], va[19:0]};
            end
            default: begin
                two = 1;
                a2  = {d1[31:10], va[19:12], 2'b00};
                case (d2[1:0])
                    2'b00: eflt = 2'd3;
                    2'b01: begin epa = {d2[31:16], va[15:0]}; exn = d2[15]; end
                    default: begin epa = {d2[31:12], va[11:0]}; exn = d2[0]; end
                endcase
            end
        endcase
    endtask

    // Answer one descriptor request after a random delay.
    task automatic serve(input logic [31:0] eaddr, input logic [31:0] data, input string tag);
        int t = 0;
        while (!mem_req && t < 20) begin step(); t++; end
        chk(mem_req == 1'b1, tag, "request", {31'd0, mem_req}, 32'd1);
        chk(mem_addr == eaddr, tag, "descriptor address", mem_addr, eaddr);
        repeat ($urandom_range(0, 2)) step();
        mem_valid = 1'b1;
        mem_rdata = data;
        step();
        mem_valid = 1'b0;
        mem_rdata = $urandom;
    endtask

    logic [31:0] last_pa;

    // One full walk, with inputs scrambled and a stray start while busy (R12).
    task automatic walk(input logic [31:0] va, input logic [31:0] b0, input logic [31:0] b1,
                        input int n, input logic [31:0] d1, input logic [31:0] d2, input string tag);
        bit two;
        logic [31:0] a2, epa;
        logic exn;
        logic [1:0] eflt;
        exp_walk(va, d1, d2, two, a2, epa, exn, eflt);
        @(negedge clk);
        start = 1'b1; start_va = va; base0 = b0; base1 = b1; split_n = 3'(n);
        @(negedge clk);
        start    = $urandom_range(0, 1) == 1;
        start_va = $urandom; base0 = $urandom; base1 = $urandom;
        split_n  = 3'($urandom);
        serve(exp_l1(va, b0, b1, n), d1, tag);
        if (two) serve(a2, d2, tag);
        chk(done == 1'b1, tag, "done after last fetch", {31'd0, done}, 32'd1);
        chk(pa == epa, tag, "pa", pa, epa);
        chk(xn == exn, tag, "xn", {31'd0, xn}, {31'd0, exn});
        chk(fault == eflt, tag, "fault", {30'd0, fault}, {30'd0, eflt});
        last_pa = pa;
        step();
        chk(done == 1'b0, "R11", "done pulse width", {31'd0, done}, 32'd0);
        chk(pa == epa, "R11", "pa held", pa, epa);
        chk(mem_req == 1'b0, "R12", "no walk from stray start", {31'd0, mem_req}, 32'd0);
    endtask

    function automatic logic [31:0] mk(input logic [31:0] r, input logic [1:0] ty);
        return {r[31:2], ty};
    endfunction

    initial begin
        logic [31:0] pa_a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0 && done == 1'b0, "R13", "idle in reset",
            {29'd0, busy, mem_req, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R13", "idle after reset",
            {30'd0, busy, mem_req}, 32'd0);
        chk(pa == 32'd0 && fault == 2'd0, "R13", "cleared results", pa, 32'd0);

        // Table base selection corners.
        walk(32'h8012_3456, 32'h1234_5678, 32'hABCD_E000, 0, 32'h4560_0002, 0, "R1");
        walk(32'h1FF0_0000, 32'h1234_5FFF, 32'hABCD_E000, 3, 32'h4560_0002, 0, "R1");
        walk(32'h2000_0000, 32'h1234_5FFF, 32'hABCD_E000, 3, 32'h4560_0002, 0, "R1");
        walk(32'h01F0_0000, 32'hFFFF_FFFF, 32'h0, 7, 32'h4560_0002, 0, "R1");
        walk(32'h0060_0000, 32'h0, 32'h0, 7, 32'h4560_0002, 0, "R1");
        // First-level kinds.
        walk(32'h1234_5678, 32'h4000_0000, 0, 0, 32'hFFFF_FFFC, 0, "R2");
        walk(32'h1234_5678, 32'h4000_0000, 0, 0, 32'hFFFF_FFFF, 0, "R3");
        walk(32'h1234_5678, 32'h4000_0000, 0, 0, 32'hABC0_0012, 0, "R4");
        walk(32'h1234_5678, 32'h4000_0000, 0, 0, 32'hDE04_0002, 0, "R5");
        // Second-level kinds.
        walk(32'h1234_5678, 32'h4000_0000, 0, 0, 32'h7777_7C01, 32'hFFFF_FFFC, "R7");
        walk(32'h1234_5678, 32'h4000_0000, 0, 0, 32'h7777_7C01, 32'hCAFE_8001, "R8");
        walk(32'h1234_5678, 32'h4000_0000, 0, 0, 32'h7777_7C01, 32'hBEEF_1002, "R9");
        walk(32'h1234_5678, 32'h4000_0000, 0, 0, 32'h7777_7C01, 32'hBEEF_1003, "R9");
        // Aliased large-page indices map to the same page (R8).
        walk(32'h1234_0678, 32'h4000_0000, 0, 0, 32'h7777_7C01, 32'h5A5A_0001, "R8");
        pa_a = last_pa;
        walk(32'h1234_F678, 32'h4000_0000, 0, 0, 32'h7777_7C01, 32'h5A5A_0001, "R8");
        chk(last_pa[31:16] == pa_a[31:16], "R8", "alias page base", last_pa, pa_a);

        // Random walks over all descriptor kinds (R6 address checked in serve).
        for (int k = 0; k < 300; k++) begin
            logic [31:0] d1 = mk($urandom, 2'($urandom));
            logic [31:0] d2 = mk($urandom, 2'($urandom));
            walk($urandom, $urandom, $urandom, $urandom_range(0, 7), d1, d2,
                 d1[1:0] == 2'b01 ? "R6" : "R1");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule